// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block holds the interrupt context of one hardware thread for a single exception level. It collects notifications from the routing logic, each carrying a 3-bit priority, into an 8-bit pending bitmap. From that bitmap it derives the most favoured pending priority and compares it with the thread's current processor priority. A numerically lower value is more favoured. When a pending priority beats the current one, the block raises the thread's interrupt line and sets the exception flag in its notification source register.

Software reaches the context through a management window of four pages. The two page-select address bits choose the view: 00 physical, 01 hypervisor, 10 operating system, 11 user. The three privileged views may write the current priority and may take an interrupt with the acknowledge load. The user view is read-only. An acknowledge load returns the source register and the pending priority together. It then promotes the current priority to the acknowledged level and retires that priority's pending bit.

Top module: `tip_presenter`

## Requirements
- R1: A cycle with `ntf_valid_i` high sets bit `ntf_prio_i` of the pending bitmap (offset 0x2); the bitmap reads back as `{8'h00, bitmap}`.
- R2: The pending-priority register (offset 0x3) reads as the index of the lowest set bitmap bit, or 0xFF when the bitmap is empty.
- R3: `irq_o` is high exactly when the pending priority is numerically less than the current priority (offset 0x1); an equal value does not interrupt. The source register (offset 0x0) reads 0x80 while the interrupt is raised and 0x00 otherwise.
- R4: After a synchronous active-low reset, the bitmap is empty, the current priority is 0x00 (everything masked), `irq_o` is low and `acc_rdata_o` is zero.
- R5: A read at offset 0x8 from pages 00, 01 or 10 with a non-empty bitmap is an acknowledge. It returns `{source register, pending priority}` on bits 15:8 and 7:0. The current priority then becomes that pending priority, and its bitmap bit is cleared.
- R6: An acknowledge with an empty bitmap returns 0x00FF and changes no state.
- R7: A write at offset 0x1 from pages 00, 01 or 10 stores `acc_wdata_i` as the current priority. `irq_o` reflects the new value in the cycle right after the write edge. A value of 0xFF unmasks all priorities.
- R8: On page 11, writes are ignored and an acknowledge returns 0x0000 with no side effect; plain register reads still work.
- R9: When a notification and an acknowledge of the same priority occur in one cycle, the new notification's bit stays set.
- R10: Read data is registered. It appears the cycle after the read and holds until the next read. Offsets other than 0x0 to 0x3 and 0x8 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ntf_valid_i | input | 1 | Notification strobe from the router |
| ntf_prio_i | input | 3 | Priority of the notification |
| acc_valid_i | input | 1 | Register access request |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_addr_i | input | 16 | Window address; bits 13:12 pick the view, bits 3:0 the register |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt line to the thread |

## Verification
The hardest case to reach is an acknowledge that coincides with a new notification of the very priority being retired. In that cycle the clear and the set land on the same bitmap bit. The bench drives both inputs in one cycle after unmasking, then reads the bitmap back to confirm the bit survived. A second hard case is an acknowledge that leaves a less favoured priority pending. It must drop the interrupt because the promoted current priority now beats it. The vector table reaches this by queuing two priorities before the acknowledge.

// File: rtl/tip_pkg.sv
// Package: shared widths, register offsets and view encoding for the
// thread interrupt presenter. Assumes 3-bit priorities (8 levels).
package tip_pkg;
    localparam int PRIO_W  = 3;
    localparam int NPRIO   = 1 << PRIO_W;
    localparam int DATA_W  = 8;
    localparam int OFF_W   = 4;

    localparam logic [OFF_W-1:0] OFF_SRC  = 4'h0;
    localparam logic [OFF_W-1:0] OFF_CUR  = 4'h1;
    localparam logic [OFF_W-1:0] OFF_PEND = 4'h2;
    localparam logic [OFF_W-1:0] OFF_BEST = 4'h3;
    localparam logic [OFF_W-1:0] OFF_TAKE = 4'h8;

    localparam logic [DATA_W-1:0] PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        VIEW_PHYS = 2'b00,
        VIEW_HV   = 2'b01,
        VIEW_OS   = 2'b10,
        VIEW_USER = 2'b11
    } view_e;
endpackage

// File: rtl/tip_best_prio.sv
// Module: finds the most favoured (lowest index) set bit of the pending
// bitmap. Purely combinational; returns PRIO_NONE for an empty bitmap.
module tip_best_prio
    import tip_pkg::*;
#(
    parameter int N = NPRIO
) (
    input  logic [N-1:0]      pend_i,
    output logic [DATA_W-1:0] best_o,
    output logic              any_o
);
    // Scan from least to most favoured so the lowest index wins.
    always_comb begin
        best_o = PRIO_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) best_o = DATA_W'(i);
        end
    end

    // Flag a non-empty bitmap.
    assign any_o = |pend_i;
endmodule

// File: rtl/tip_view_decode.sv
// Module: splits a window address into view and register offset and
// gives the view's rights. Assumes the view bits sit at PAGE_LSB.
module tip_view_decode
    import tip_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output view_e             view_o,
    output logic [OFF_W-1:0]  off_o,
    output logic              priv_o
);
    // Extract the view and register offset fields.
    assign view_o = view_e'(addr_i[PAGE_LSB+1:PAGE_LSB]);
    assign off_o  = addr_i[OFF_W-1:0];

    // Every view above user may change state.
    always_comb begin
        unique case (view_o)
            VIEW_PHYS, VIEW_HV, VIEW_OS: priv_o = 1'b1;
            default:                     priv_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tip_context.sv
// Module: the state of one exception level's context: pending bitmap
// and current priority. Assumes the caller only raises take_i when the
// bitmap is non-empty.
module tip_context
    import tip_pkg::*;
#(
    parameter int N = NPRIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid_i,
    input  logic [PRIO_W-1:0] ntf_prio_i,
    input  logic              cur_we_i,
    input  logic [DATA_W-1:0] cur_wdata_i,
    input  logic              take_i,
    output logic [N-1:0]      pend_o,
    output logic [DATA_W-1:0] cur_o,
    output logic [DATA_W-1:0] best_o,
    output logic              eo_o
);
    logic [N-1:0] set_mask;
    logic [N-1:0] clr_mask;
    logic         any_pend;

    tip_best_prio #(.N(N)) u_best (
        .pend_i (pend_o),
        .best_o (best_o),
        .any_o  (any_pend)
    );

    // Build per-bit set and clear masks from notification and acknowledge.
    for (genvar g = 0; g < N; g++) begin : g_mask
        assign set_mask[g] = ntf_valid_i && (ntf_prio_i == PRIO_W'(g));
        assign clr_mask[g] = take_i && (best_o == DATA_W'(g));
    end

    // Pending bitmap: clear first, then set, so a new notification survives.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_mask) | set_mask;
    end

    // Current priority: acknowledge promotes, software write replaces.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_o <= '0;
        else if (take_i)   cur_o <= best_o;
        else if (cur_we_i) cur_o <= cur_wdata_i;
    end

    // Exception pending when the best pending level beats the current one.
    assign eo_o = any_pend && (best_o < cur_o);
endmodule

// File: rtl/tip_presenter.sv
// Module: top of the thread interrupt presenter. Decodes window
// accesses, drives the context and returns registered read data.
// Assumes one access per cycle; reads complete on the next cycle.
module tip_presenter
    import tip_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid_i,
    input  logic [PRIO_W-1:0] ntf_prio_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    output logic [2*DATA_W-1:0] acc_rdata_o,
    output logic              irq_o
);
    view_e              view;
    logic [OFF_W-1:0]   off;
    logic               priv;
    logic [NPRIO-1:0]   pend_q;
    logic [DATA_W-1:0]  cur_q;
    logic [DATA_W-1:0]  best;
    logic               eo;
    logic [DATA_W-1:0]  src_reg;
    logic               rd_req;
    logic               cur_we;
    logic               take;
    logic [2*DATA_W-1:0] rd_next;

    tip_view_decode #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_dec (
        .addr_i (acc_addr_i),
        .view_o (view),
        .off_o  (off),
        .priv_o (priv)
    );

    // Qualify the access strobes with the view's rights.
    assign rd_req = acc_valid_i && !acc_write_i;
    assign cur_we = acc_valid_i && acc_write_i && priv && (off == OFF_CUR);
    assign take   = rd_req && priv && (off == OFF_TAKE) && (pend_q != '0);

    tip_context #(.N(NPRIO)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ntf_valid_i (ntf_valid_i),
        .ntf_prio_i  (ntf_prio_i),
        .cur_we_i    (cur_we),
        .cur_wdata_i (acc_wdata_i),
        .take_i      (take),
        .pend_o      (pend_q),
        .cur_o       (cur_q),
        .best_o      (best),
        .eo_o        (eo)
    );

    // Source register: exception flag in the top bit.
    assign src_reg = {eo, {(DATA_W-1){1'b0}}};

    // Select the value a read returns.
    always_comb begin
        rd_next = '0;
        unique case (off)
            OFF_SRC:  rd_next = {{DATA_W{1'b0}}, src_reg};
            OFF_CUR:  rd_next = {{DATA_W{1'b0}}, cur_q};
            OFF_PEND: rd_next = {{DATA_W{1'b0}}, DATA_W'(pend_q)};
            OFF_BEST: rd_next = {{DATA_W{1'b0}}, best};
            OFF_TAKE: rd_next = priv ? {src_reg, best} : '0;
            default:  rd_next = '0;
        endcase
    end

    // Read data register: loads on a read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_rdata_o <= '0;
        else if (rd_req) acc_rdata_o <= rd_next;
    end

    // The interrupt line follows the exception flag.
    assign irq_o = eo;

    // view is only used through priv; keep it observable for the checker.
    logic unused_view;
    assign unused_view = ^view;
endmodule

// File: rtl/tip_presenter_chk.sv
// Module: assertion checker for tip_presenter, attached by bind.
module tip_presenter_chk
    import tip_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ntf_valid_i,
    input logic [PRIO_W-1:0] ntf_prio_i,
    input logic              acc_valid_i,
    input logic              acc_write_i,
    input logic [15:0]       acc_addr_i,
    input logic [DATA_W-1:0] acc_wdata_i,
    input logic [15:0]       acc_rdata_o,
    input logic              irq_o,
    input logic [NPRIO-1:0]  pend_q,
    input logic [DATA_W-1:0] cur_q,
    input logic [DATA_W-1:0] best,
    input logic              take
);
    assert_ntf_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid_i |=> pend_q[$past(ntf_prio_i)]);

    assert_empty_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (best == PRIO_NONE));

    assert_irq_needs_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q != '0));

    assert_take_promotes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur_q == $past(best)));

    assert_take_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ntf_valid_i) |=> !irq_o);

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && acc_addr_i[13:12] != 2'b11
         && acc_addr_i[3:0] == OFF_CUR && !take) |=> (cur_q == $past(acc_wdata_i)));

    assert_user_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_addr_i[13:12] == 2'b11 && !ntf_valid_i) |=>
        ($stable(cur_q) && $stable(pend_q)));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid_i && !acc_write_i) |=> $stable(acc_rdata_o));
endmodule

bind tip_presenter tip_presenter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ntf_valid_i (ntf_valid_i),
    .ntf_prio_i  (ntf_prio_i),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_addr_i  (acc_addr_i),
    .acc_wdata_i (acc_wdata_i),
    .acc_rdata_o (acc_rdata_o),
    .irq_o       (irq_o),
    .pend_q      (pend_q),
    .cur_q       (cur_q),
    .best        (best),
    .take        (take)
);

// File: tb/tip_presenter_bench.sv
module tip_presenter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ntf_valid_i;
    logic [2:0]  ntf_prio_i;
    logic        acc_valid_i;
    logic        acc_write_i;
    logic [15:0] acc_addr_i;
    logic [7:0]  acc_wdata_i;
    logic [15:0] acc_rdata_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    tip_presenter u_tip_presenter (
        .clk(clk), .rst_n(rst_n),
        .ntf_valid_i(ntf_valid_i), .ntf_prio_i(ntf_prio_i),
        .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
        .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i),
        .acc_rdata_o(acc_rdata_o), .irq_o(irq_o)
    );

    // vector: op(2) page(2) off(4) data(8) exp_rdata(16) exp_irq(1) req(4)
    // op: 0 notify (data[2:0] = priority), 1 write, 2 read
    localparam int NV = 23;
    localparam logic [36:0] VEC [NV] = '{
        {2'd2, 2'd2, 4'h1, 8'h00, 16'h0000, 1'b0, 4'd4},  // R4 current prio 0
        {2'd2, 2'd2, 4'h3, 8'h00, 16'h00FF, 1'b0, 4'd2},  // R2 empty -> FF
        {2'd0, 2'd0, 4'h0, 8'h05, 16'h0000, 1'b0, 4'd3},  // R3 masked by 0
        {2'd2, 2'd2, 4'h2, 8'h00, 16'h0020, 1'b0, 4'd1},  // R1 bit 5
        {2'd2, 2'd2, 4'h3, 8'h00, 16'h0005, 1'b0, 4'd2},  // R2
        {2'd1, 2'd2, 4'h1, 8'hFF, 16'h0005, 1'b1, 4'd7},  // R7 unmask (rdata held)
        {2'd2, 2'd2, 4'h0, 8'h00, 16'h0080, 1'b1, 4'd3},  // R3 source reg
        {2'd0, 2'd0, 4'h0, 8'h02, 16'h0080, 1'b1, 4'd1},  // R1
        {2'd2, 2'd2, 4'h3, 8'h00, 16'h0002, 1'b1, 4'd2},  // R2 lowest wins
        {2'd2, 2'd2, 4'h8, 8'h00, 16'h8002, 1'b0, 4'd5},  // R5 ack
        {2'd2, 2'd2, 4'h1, 8'h00, 16'h0002, 1'b0, 4'd5},  // R5 promoted
        {2'd2, 2'd2, 4'h2, 8'h00, 16'h0020, 1'b0, 4'd5},  // R5 bit cleared
        {2'd1, 2'd3, 4'h1, 8'hFF, 16'h0020, 1'b0, 4'd8},  // R8 user write
        {2'd2, 2'd3, 4'h1, 8'h00, 16'h0002, 1'b0, 4'd8},  // R8 user read
        {2'd2, 2'd3, 4'h8, 8'h00, 16'h0000, 1'b0, 4'd8},  // R8 user ack
        {2'd2, 2'd0, 4'h2, 8'h00, 16'h0020, 1'b0, 4'd8},  // R8 no side effect
        {2'd1, 2'd1, 4'h1, 8'h06, 16'h0020, 1'b1, 4'd7},  // R7 hv write
        {2'd1, 2'd0, 4'h1, 8'h05, 16'h0020, 1'b0, 4'd3},  // R3 equal no irq
        {2'd2, 2'd2, 4'h5, 8'h00, 16'h0000, 1'b0, 4'd10}, // R10 unmapped
        {2'd1, 2'd2, 4'h1, 8'hFF, 16'h0000, 1'b1, 4'd7},  // R7
        {2'd2, 2'd0, 4'h8, 8'h00, 16'h8005, 1'b0, 4'd5},  // R5 phys ack
        {2'd2, 2'd2, 4'h8, 8'h00, 16'h00FF, 1'b0, 4'd6},  // R6 empty ack
        {2'd2, 2'd2, 4'h1, 8'h00, 16'h0005, 1'b0, 4'd6}   // R6 unchanged
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ntf_valid_i = 1'b0; ntf_prio_i = '0; acc_valid_i = 1'b0;
        acc_write_i = 1'b0; acc_addr_i = '0; acc_wdata_i = '0;
    endtask

    // Drive one operation at a falling edge; outputs sampled one cycle later.
    task automatic do_op(input logic [1:0] op, input logic [1:0] pg,
                         input logic [3:0] off, input logic [7:0] d);
        if (op == 2'd0) begin
            ntf_valid_i = 1'b1; ntf_prio_i = d[2:0];
        end else begin
            acc_valid_i = 1'b1; acc_write_i = (op == 2'd1);
            acc_addr_i = {2'b00, pg, 8'h00, off}; acc_wdata_i = d;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4 reset state at the ports
        check("R4 irq", {15'd0, irq_o}, 16'h0000);
        check("R4 rdata", acc_rdata_o, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][36:35], VEC[i][34:33], VEC[i][32:29], VEC[i][28:21]);
            if (VEC[i][36:35] == 2'd2)
                check($sformatf("R%0d vec%0d rdata", VEC[i][3:0], i), acc_rdata_o, VEC[i][20:5]);
            check($sformatf("R%0d vec%0d irq", VEC[i][3:0], i), {15'd0, irq_o}, {15'd0, VEC[i][4]});
        end

        // R9: notification and acknowledge of the same priority together
        do_op(2'd0, 2'd0, 4'h0, 8'h03);
        do_op(2'd1, 2'd2, 4'h1, 8'hFF);
        check("R9 irq before", {15'd0, irq_o}, 16'h0001);
        ntf_valid_i = 1'b1; ntf_prio_i = 3'd3;
        do_op(2'd2, 2'd2, 4'h8, 8'h00);
        check("R9 ack data", acc_rdata_o, 16'h8003);
        check("R9 irq after", {15'd0, irq_o}, 16'h0000);
        do_op(2'd2, 2'd2, 4'h2, 8'h00);
        check("R9 bit kept", acc_rdata_o, 16'h0008);

        // R10: read data holds over idle cycles
        repeat (3) @(negedge clk);
        check("R10 hold", acc_rdata_o, 16'h0008);

        // R4: reset in the middle of activity
        do_op(2'd1, 2'd2, 4'h1, 8'hFF);
        check("R4 pre irq", {15'd0, irq_o}, 16'h0001);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R4 irq cleared", {15'd0, irq_o}, 16'h0000);
        check("R4 rdata cleared", acc_rdata_o, 16'h0000);
        do_op(2'd2, 2'd0, 4'h2, 8'h00);
        check("R4 bitmap empty", acc_rdata_o, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule